// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers hardware interrupt requests for a processor core and decides when the core is to be interrupted and which source it serves. Each of the active-low request lines passes through a synchronizer. A falling edge on a line records a pending flag for that line. A per-line enable register and a single global disable bit gate the flags. One non-maskable request line ignores both gates and always has the highest priority.

A three-state machine presents the choice to the core and then waits for the core's handshake. In IDLE it looks at the gated candidates. If it finds one, it latches the winning vector index and moves to OFFER, where `irq_pending` is high. When the core asserts `take_i`, the machine moves to ACK. On that move it clears the winner's flag and sets the global disable bit, so that a nested maskable interrupt cannot be taken. ACK drives the active-low acknowledge for exactly one cycle and then returns to IDLE. Software clears pending flags by writing ones to them, loads the enable register, and sets or clears the global disable bit through two control inputs.

Transitions: IDLE→OFFER when a candidate exists; OFFER→ACK when `take_i` is high; ACK→IDLE always; otherwise the state holds.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, `irq_pending` is 0, `iack_n` is 1, `gdis_o` is 1, and all pending flags and enable bits are 0.
- R2: A high-to-low transition on `req_n[i]` sets pending flag i. A line held low sets it once only, and does not set it again after the flag is cleared.
- R3: A pending flag whose enable bit is 0 never raises `irq_pending`. The flag is kept, and it is offered once its enable bit is written to 1.
- R4: While `gdis_o` is 1, no maskable flag is offered. Once `gdis_o` is 0, an enabled pending flag is offered.
- R5: A falling edge on `nmi_n` is offered with `vec_idx` equal to NUM_LINES, whatever the enable bits and `gdis_o` hold. It wins over any maskable flag.
- R6: Among enabled pending maskable flags, the lowest index is offered.
- R7: A `take_i` sampled high in OFFER leads to `iack_n` being low for exactly the next cycle. On the same edge the served flag is cleared and `gdis_o` becomes 1.
- R8: A write with `reg_wr_sel`=0 clears each pending flag whose data bit is 1 and leaves the others unchanged. A falling edge that lands in the same cycle still sets its flag. A write with `reg_wr_sel`=1 loads the enable register.
- R9: Once a vector has been offered, `vec_idx` stays stable until it is taken, even when new requests or writes arrive.
- R10: `gdis_set` sets `gdis_o` to 1 and `gdis_clr` clears it. When both are high, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | NUM_LINES | Active-low asynchronous maskable request lines |
| nmi_n | input | 1 | Active-low asynchronous non-maskable request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 = clear pending flags, 1 = load enable register |
| reg_wr_data | input | NUM_LINES | Write data |
| gdis_set | input | 1 | Set the global disable bit |
| gdis_clr | input | 1 | Clear the global disable bit |
| take_i | input | 1 | Core accepts the offered interrupt |
| irq_pending | output | 1 | An interrupt is offered to the core |
| vec_idx | output | $clog2(NUM_LINES)+1 | Index of the offered source; NUM_LINES means non-maskable |
| iack_n | output | 1 | Active-low one-cycle acknowledge |
| gdis_o | output | 1 | Current global disable bit |

## Verification
The hardest case to reach from the ports is a flag-clear write that lands on the same clock edge on which a synchronized falling edge sets the same flag. The bench drives the request low and then waits exactly two falling clock edges before raising the write strobe, so that the write strobe and the set meet on the same edge. A second hard case is an offer that must stay fixed while a lower-index request and register writes arrive. The bench reaches it by holding off `take_i` during OFFER. A behavioural model steps every clock and is compared with the outputs throughout.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_ACK   = 2'd2
    } irq_state_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_n,
    output logic [W-1:0] fall
);
    logic [STAGES-1:0][W-1:0] pipe_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
            prev_q <= '1;
        end else begin
            pipe_q[0] <= async_n;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~pipe_q[STAGES-1];
endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int W  = 16,
    parameter int IW = 5
) (
    input  logic [W-1:0]  cand,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |cand;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_gate_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int SYNC_STAGES = 2,
    localparam int VEC_W      = $clog2(NUM_LINES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_n,
    input  logic                 nmi_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_wr_sel,
    input  logic [NUM_LINES-1:0] reg_wr_data,
    input  logic                 gdis_set,
    input  logic                 gdis_clr,
    input  logic                 take_i,
    output logic                 irq_pending,
    output logic [VEC_W-1:0]     vec_idx,
    output logic                 iack_n,
    output logic                 gdis_o
);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_LINES);

    irq_state_t             state_q, state_d;
    logic [VEC_W-1:0]       vec_q, vec_d;
    logic [NUM_LINES-1:0]   flag_q, mask_q, line_fall, take_clr, wr_clr;
    logic                   nmi_q, nmi_fall, gdis_q, take_ok;
    logic                   cand_any;
    logic [VEC_W-1:0]       cand_idx;

    irq_edge_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_line_sync (
        .clk(clk), .rst_n(rst_n), .async_n(req_n), .fall(line_fall)
    );

    irq_edge_sync #(.W(1), .STAGES(SYNC_STAGES)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .async_n(nmi_n), .fall(nmi_fall)
    );

    irq_pick_lowest #(.W(NUM_LINES), .IW(VEC_W)) u_pick (
        .cand(flag_q & mask_q & {NUM_LINES{~gdis_q}}),
        .any(cand_any),
        .idx(cand_idx)
    );

    assign take_ok = (state_q == ST_OFFER) && take_i;
    assign wr_clr  = (reg_wr_en && !reg_wr_sel) ? reg_wr_data : '0;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
        assign take_clr[g] = take_ok && (vec_q == VEC_W'(g));
    end

    // pending flags, enable register, non-maskable latch, global disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            mask_q <= '0;
            nmi_q  <= 1'b0;
            gdis_q <= 1'b1;
        end else begin
            flag_q <= (flag_q & ~wr_clr & ~take_clr) | line_fall;
            if (reg_wr_en && reg_wr_sel) mask_q <= reg_wr_data;
            nmi_q  <= (nmi_q && !(take_ok && vec_q == NMI_VEC)) || nmi_fall;
            if (take_ok || gdis_set) gdis_q <= 1'b1;
            else if (gdis_clr)       gdis_q <= 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        vec_d   = vec_q;
        unique case (state_q)
            ST_IDLE: begin
                if (nmi_q) begin
                    state_d = ST_OFFER;
                    vec_d   = NMI_VEC;
                end else if (cand_any) begin
                    state_d = ST_OFFER;
                    vec_d   = cand_idx;
                end
            end
            ST_OFFER: if (take_i) state_d = ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
        end
    end

    // outputs
    always_comb begin
        irq_pending = (state_q == ST_OFFER);
        iack_n      = (state_q != ST_ACK);
        vec_idx     = vec_q;
        gdis_o      = gdis_q;
    end
endmodule

// File: rtl/irq_gate_checks.sv
module irq_gate_checks #(
    parameter int NUM_LINES = 16,
    localparam int VEC_W    = $clog2(NUM_LINES) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_i,
    input logic             irq_pending,
    input logic [VEC_W-1:0] vec_idx,
    input logic             iack_n,
    input logic             gdis_o
);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_LINES);

    assert_ack_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_n |=> iack_n);

    assert_ack_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iack_n) |-> $past(irq_pending && take_i));

    assert_gdis_during_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_n |-> gdis_o);

    assert_offer_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && $past(irq_pending)) |-> $stable(vec_idx));

    assert_gdis_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_pending) && vec_idx != NMI_VEC) |-> $past(!gdis_o));

    assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> vec_idx <= NMI_VEC);
endmodule

bind irq_gate_ctrl irq_gate_checks #(.NUM_LINES(NUM_LINES)) u_checks (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .irq_pending(irq_pending),
    .vec_idx(vec_idx), .iack_n(iack_n), .gdis_o(gdis_o)
);

// File: tb/irq_gate_ctrl_test.sv
module irq_gate_ctrl_test;
    localparam int N  = 16;
    localparam int VW = $clog2(N) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] req_n = '1;
    logic nmi_n = 1'b1, reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
    logic [N-1:0] reg_wr_data = '0;
    logic gdis_set = 1'b0, gdis_clr = 1'b0, take_i = 1'b0;
    logic irq_pending, iack_n, gdis_o;
    logic [VW-1:0] vec_idx;

    int tests = 0, fails = 0, cycles = 0;
    string cur = "R1";

    always #10 clk = ~clk;

    irq_gate_ctrl #(.NUM_LINES(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .nmi_n(nmi_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .gdis_set(gdis_set), .gdis_clr(gdis_clr), .take_i(take_i),
        .irq_pending(irq_pending), .vec_idx(vec_idx), .iack_n(iack_n), .gdis_o(gdis_o)
    );

    // behavioural reference model
    logic [N-1:0] m_s1, m_s2, m_prev, m_flag, m_mask;
    logic m_n1, m_n2, m_nprev, m_nmi, m_gdis;
    int m_state, m_vec;

    always @(posedge clk) begin
        logic [N-1:0] nf;
        logic tk;
        int nstate, nvec;
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_prev = '1; m_flag = '0; m_mask = '0;
            m_n1 = 1; m_n2 = 1; m_nprev = 1; m_nmi = 0; m_gdis = 1;
            m_state = 0; m_vec = 0;
        end else begin
            tk = (m_state == 1) && take_i;
            nstate = m_state; nvec = m_vec;
            if (m_state == 0) begin
                if (m_nmi) begin nstate = 1; nvec = N; end
                else if (!m_gdis && (m_flag & m_mask) != 0) begin
                    for (int i = N - 1; i >= 0; i--) if (m_flag[i] && m_mask[i]) nvec = i;
                    nstate = 1;
                end
            end else if (m_state == 1) begin
                if (take_i) nstate = 2;
            end else nstate = 0;
            nf = m_flag;
            if (reg_wr_en && !reg_wr_sel) nf = nf & ~reg_wr_data;
            if (tk && m_vec < N) nf[m_vec] = 1'b0;
            nf = nf | (m_prev & ~m_s2);
            if (tk && m_vec == N) m_nmi = 0;
            if (m_nprev && !m_n2) m_nmi = 1;
            if (reg_wr_en && reg_wr_sel) m_mask = reg_wr_data;
            if (tk || gdis_set) m_gdis = 1; else if (gdis_clr) m_gdis = 0;
            m_flag = nf; m_state = nstate; m_vec = nvec;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = req_n;
            m_nprev = m_n2; m_n2 = m_n1; m_n1 = nmi_n;
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk({cur, " pending"}, int'(irq_pending), int'(m_state == 1));
            chk({cur, " iack_n"}, int'(iack_n), int'(m_state != 2));
            chk({cur, " gdis"}, int'(gdis_o), int'(m_gdis));
            if (irq_pending) chk({cur, " vec"}, int'(vec_idx), m_vec);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(logic [N-1:0] bits);
        @(negedge clk) req_n = req_n & ~bits;
        tick(2);
        req_n = req_n | bits;
    endtask

    task automatic reg_write(logic sel, logic [N-1:0] d);
        @(negedge clk) begin reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d; end
        @(negedge clk) reg_wr_en = 0;
    endtask

    task automatic gd(logic s, logic c);
        @(negedge clk) begin gdis_set = s; gdis_clr = c; end
        @(negedge clk) begin gdis_set = 0; gdis_clr = 0; end
    endtask

    task automatic take_it(string tag);
        @(negedge clk) take_i = 1;
        @(negedge clk) take_i = 0;
        chk({tag, " iack low"}, int'(iack_n), 0);
        chk({tag, " gdis set on take"}, int'(gdis_o), 1);
        @(negedge clk);
        chk({tag, " iack back high"}, int'(iack_n), 1);
    endtask

    initial begin
        tick(3);
        cur = "R1";
        chk("R1 pending at reset", int'(irq_pending), 0);
        chk("R1 iack at reset", int'(iack_n), 1);
        chk("R1 gdis at reset", int'(gdis_o), 1);
        @(negedge clk) rst_n = 1;
        tick(2);

        // R3: masked flag held, offered once enabled
        cur = "R3";
        gd(0, 1);
        @(negedge clk) req_n[3] = 0;       // line 3 stays low
        tick(8);
        chk("R3 masked not offered", int'(irq_pending), 0);
        reg_write(1, 16'h0008);
        tick(3);
        chk("R3 offered after enable", int'(irq_pending), 1);
        chk("R3 vec", int'(vec_idx), 3);
        cur = "R7";
        take_it("R7");
        chk("R7 pending dropped", int'(irq_pending), 0);

        // R2: level held low does not set again
        cur = "R2";
        gd(0, 1);
        tick(8);
        chk("R2 no retrigger on level", int'(irq_pending), 0);
        @(negedge clk) req_n[3] = 1;

        // R4 / R6: global disable, lowest index
        cur = "R4";
        reg_write(1, 16'hFFFF);
        gd(1, 0);
        pulse_req(16'h0220);
        tick(6);
        chk("R4 blocked by gdis", int'(irq_pending), 0);
        gd(0, 1);
        tick(2);
        chk("R4 offered after clear", int'(irq_pending), 1);
        cur = "R6";
        chk("R6 lowest index wins", int'(vec_idx), 5);
        take_it("R6");
        tick(4);
        chk("R7 nesting blocked", int'(irq_pending), 0);
        gd(0, 1);
        tick(2);
        chk("R6 next line", int'(vec_idx), 9);
        take_it("R6");

        // R8: write-one-to-clear, zeros untouched
        cur = "R8";
        pulse_req(16'h0014);
        tick(3);
        reg_write(0, 16'h0004);
        gd(0, 1);
        tick(2);
        chk("R8 cleared bit skipped", int'(vec_idx), 4);
        take_it("R8");
        // clear write coinciding with a new edge on line 7
        @(negedge clk) req_n[7] = 0;
        tick(2);
        reg_wr_en = 1; reg_wr_sel = 0; reg_wr_data = 16'h0080;
        @(negedge clk) begin reg_wr_en = 0; req_n[7] = 1; end
        gd(0, 1);
        tick(2);
        chk("R8 edge beats clear", int'(irq_pending), 1);
        chk("R8 vec 7", int'(vec_idx), 7);
        take_it("R8");

        // R5: NMI bypasses gating and wins
        cur = "R5";
        reg_write(1, 16'h0001);
        @(negedge clk) begin req_n[0] = 0; nmi_n = 0; end
        tick(2);
        begin req_n[0] = 1; nmi_n = 1; end
        tick(4);
        chk("R5 nmi offered under gdis", int'(irq_pending), 1);
        chk("R5 nmi vec", int'(vec_idx), N);
        take_it("R5");
        gd(0, 1);
        tick(2);
        chk("R5 maskable after nmi", int'(vec_idx), 0);
        take_it("R5");

        // R10: set/clear of global disable
        cur = "R10";
        gd(1, 1);
        chk("R10 set wins", int'(gdis_o), 1);
        gd(0, 1);
        chk("R10 clear", int'(gdis_o), 0);
        gd(1, 0);
        chk("R10 set", int'(gdis_o), 1);

        // R9: offer held while new requests arrive
        cur = "R9";
        reg_write(1, 16'h0042);
        pulse_req(16'h0040);
        tick(3);
        gd(0, 1);
        tick(2);
        chk("R9 first offer", int'(vec_idx), 6);
        pulse_req(16'h0002);
        reg_write(1, 16'hFFFF);
        tick(5);
        chk("R9 offer stays", int'(vec_idx), 6);
        take_it("R9");
        gd(0, 1);
        tick(2);
        chk("R9 lower line next", int'(vec_idx), 1);
        take_it("R9");
        tick(4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule